// File: doc/BRIEF.md
# Fine-Grain Pipelined Three-Tap FIR Filter

This block is a streaming three-tap FIR filter for signed two's-complement samples and coefficients. Each accepted sample `in_data` is combined with the two previously accepted samples as `y = ca·x(n) + cb·x(n-1) + cc·x(n-2)`. The result is a full-precision output with no rounding and no saturation. The block takes one sample per clock. A cycle with `in_vld` low is a bubble: it leaves the sample history unchanged and produces no output.

Registers sit only on feed-forward cuts, and every path runs from input to output. Each multiplier is split into two registered halves. The first half forms two partial products, one from the unsigned low part of the coefficient and one from the signed high part. The second half shifts the high partial product and adds the two into the full product. Two adder stages then reduce the three products. The longest combinational path is therefore one partial multiply or one adder. A matching valid shift register flags each result exactly when it leaves the pipeline.

Top module: `fir3_fg_top`

## Requirements
- R1: For every accepted sample x(n), out_data equals ca·x(n) + cb·x(n-1) + cc·x(n-2) in signed arithmetic, where x(n-1) and x(n-2) are the two previously accepted samples and ca, cb, cc are the coefficient values present when x(n) is accepted.
- R2: out_vld is high after a rising edge exactly when in_vld was high at the fourth rising edge before it, counting the edge that captured the sample as the first. In every other cycle out_vld is low.
- R3: A cycle with in_vld low does not shift the sample history. The next accepted sample uses the same two earlier samples it would have used without the bubble.
- R4: While rst is high at a rising edge, out_vld and out_data are zero after that edge. History slots not yet filled since reset count as zero samples, and their outputs are still flagged valid.
- R5: The output is exact at the extremes: the most negative sample with the most negative coefficient on all three taps, and coefficients whose low part is all ones. The output width is sample width plus coefficient width plus 2 bits.
- R6: The value on in_data during a cycle with in_vld low has no effect on any later output.
- R7: A reset in the middle of a stream discards every sample in flight, so no valid output appears for them. The sample history also returns to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample on in_data is accepted this cycle |
| in_data | input | DW | Signed input sample |
| coef_a | input | CW | Signed coefficient for the newest sample |
| coef_b | input | CW | Signed coefficient for the previous sample |
| coef_c | input | CW | Signed coefficient for the sample before that |
| out_vld | output | 1 | out_data holds a new filtered sample |
| out_data | output | DW+CW+2 | Signed full-precision filter output |

## Verification
The in-RTL properties assume that the inputs carry known values and that reset is held for at least one edge. They measure every multi-cycle relation against a counter of cycles since reset, so values presented during reset are never compared. The end-to-end reference in the bench assumes the coefficients stay constant while samples are in flight through the pipeline. To respect this, the stimulus changes coefficients only after at least four bubble cycles. Random bursts mix valid and bubble cycles, with random data on the bubbles, and directed cases cover the extreme values and a reset in the middle of a stream.

// File: rtl/fir3_pkg.sv
`timescale 1ns/1ps
package fir3_pkg;
  // number of filter taps
  localparam int FIR_TAPS = 3;
  // register levels from input to output: partial product, full product,
  // first adder, second adder
  localparam int FIR_LAT  = 4;
endpackage

// File: rtl/fir3_hist.sv
`timescale 1ns/1ps
// Sample history: two delayed copies of the accepted input stream.
module fir3_hist #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data,
  output logic signed [DW-1:0] tap0,
  output logic signed [DW-1:0] tap1,
  output logic signed [DW-1:0] tap2
);
  logic signed [DW-1:0] d1_q, d2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d1_q <= '0;
      d2_q <= '0;
    end else if (in_vld) begin
      d1_q <= in_data;
      d2_q <= d1_q;
    end
  end

  assign tap0 = in_data;
  assign tap1 = d1_q;
  assign tap2 = d2_q;

  // R3: a bubble leaves the history untouched
  p_hold_on_bubble_r3: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(d1_q) && $stable(d2_q)));

  // R1: an accepted sample shifts the history by one
  p_shift_on_accept_r1: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> (d1_q == $past(in_data) && d2_q == $past(d1_q)));
endmodule

// File: rtl/fir3_split_mul.sv
`timescale 1ns/1ps
// Two-stage multiplier: the coefficient is cut into an unsigned low part
// and a signed high part; both partial products are registered, then
// shifted and summed in the second stage.
module fir3_split_mul #(
  parameter int DW = 12,
  parameter int CW = 10,
  parameter int LO = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [DW-1:0]    x,
  input  logic signed [CW-1:0]    coef,
  output logic signed [DW+CW-1:0] prod
);
  localparam int HI  = CW - LO;
  localparam int PLW = DW + LO + 1;
  localparam int PHW = DW + HI;
  localparam int PW  = DW + CW;

  logic signed [LO:0]    lo_ext;
  logic signed [HI-1:0]  hi_part;
  logic signed [PLW-1:0] pl_d, pl_q;
  logic signed [PHW-1:0] ph_d, ph_q;
  logic signed [PW-1:0]  prod_d, prod_q;

  assign lo_ext  = $signed({1'b0, coef[LO-1:0]});
  assign hi_part = $signed(coef[CW-1:LO]);
  assign pl_d    = PLW'(x) * PLW'(lo_ext);
  assign ph_d    = PHW'(x) * PHW'(hi_part);

  // stage m1: partial products
  always_ff @(posedge clk) begin
    if (rst) begin
      pl_q <= '0;
      ph_q <= '0;
    end else begin
      pl_q <= pl_d;
      ph_q <= ph_d;
    end
  end

  assign prod_d = (PW'(ph_q) <<< LO) + PW'(pl_q);

  // stage m2: recombined product
  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= prod_d;
  end

  assign prod = prod_q;

  // cycles since reset, saturating at the two-stage depth
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R1, R5: recombined halves equal the full signed product two cycles on
  p_split_exact_r5: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (prod_q == PW'($past(x, 2)) * PW'($past(coef, 2))));
endmodule

// File: rtl/fir3_sum.sv
`timescale 1ns/1ps
// Two-level registered adder tree for three products.
module fir3_sum #(
  parameter int PW = 22,
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [PW-1:0] p0,
  input  logic signed [PW-1:0] p1,
  input  logic signed [PW-1:0] p2,
  output logic signed [OW-1:0] y
);
  logic signed [OW-1:0] s01_q, p2_q, y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s01_q <= '0;
      p2_q  <= '0;
      y_q   <= '0;
    end else begin
      s01_q <= OW'(p0) + OW'(p1);
      p2_q  <= OW'(p2);
      y_q   <= s01_q + p2_q;
    end
  end

  assign y = y_q;

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R1: the tree output is the sum of products seen two edges earlier
  p_tree_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (y_q == $past(OW'(p0) + OW'(p1) + OW'(p2), 2)));
endmodule

// File: rtl/fir3_vld_pipe.sv
`timescale 1ns/1ps
// Valid flag delay line matching the data pipeline depth.
module fir3_vld_pipe #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_in,
  output logic vld_out
);
  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= vld_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[DEPTH-2:0], vld_in};
      end
    end
  endgenerate

  assign vld_out = sr_q[DEPTH-1];
endmodule

// File: rtl/fir3_fg_top.sv
`timescale 1ns/1ps
// Fine-grain pipelined three-tap FIR filter.
module fir3_fg_top
  import fir3_pkg::*;
#(
  parameter  int DW = 12,
  parameter  int CW = 10,
  parameter  int LO = CW / 2,
  localparam int OW = DW + CW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_data
);
  localparam int PW = DW + CW;

  logic signed [DW-1:0] tap  [FIR_TAPS];
  logic signed [CW-1:0] coef [FIR_TAPS];
  logic signed [PW-1:0] prod [FIR_TAPS];

  assign coef[0] = coef_a;
  assign coef[1] = coef_b;
  assign coef[2] = coef_c;

  fir3_hist #(.DW(DW)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_data (in_data),
    .tap0    (tap[0]),
    .tap1    (tap[1]),
    .tap2    (tap[2])
  );

  generate
    for (genvar k = 0; k < FIR_TAPS; k++) begin : g_tap
      fir3_split_mul #(.DW(DW), .CW(CW), .LO(LO)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .x    (tap[k]),
        .coef (coef[k]),
        .prod (prod[k])
      );
    end
  endgenerate

  fir3_sum #(.PW(PW), .OW(OW)) u_sum (
    .clk (clk),
    .rst (rst),
    .p0  (prod[0]),
    .p1  (prod[1]),
    .p2  (prod[2]),
    .y   (out_data)
  );

  fir3_vld_pipe #(.DEPTH(FIR_LAT)) u_vld (
    .clk     (clk),
    .rst     (rst),
    .vld_in  (in_vld),
    .vld_out (out_vld)
  );

  // cycles since reset, saturating at the pipeline depth
  logic [2:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                       age_q <= '0;
    else if (age_q != 3'(FIR_LAT)) age_q <= age_q + 3'd1;
  end

  // R2: output valid follows input valid by exactly four edges
  p_vld_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (age_q == 3'(FIR_LAT)) |-> (out_vld == $past(in_vld, 4)));

  // R7: right after reset, nothing in flight can surface early
  p_no_early_vld_r7: assert property (@(posedge clk) disable iff (rst)
    (age_q < 3'(FIR_LAT)) |-> !out_vld);

  // R4: a reset edge clears the outputs
  p_rst_clears_r4: assert property (@(posedge clk)
    rst |=> (!out_vld && out_data == '0));
endmodule

// File: tb/fir3_fg_top_bench.sv
`timescale 1ns/1ps
module fir3_fg_top_bench;
  localparam int DW = 12;
  localparam int CW = 10;
  localparam int OW = DW + CW + 2;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_vld = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic signed [CW-1:0] coef_a = '0, coef_b = '0, coef_c = '0;
  logic                 out_vld;
  logic signed [OW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  longint h1 = 0, h2 = 0;
  bit     slot_v [8];
  longint slot_d [8];

  always #2 clk = ~clk;

  fir3_fg_top #(.DW(DW), .CW(CW)) u_fir3_fg_top (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .out_vld(out_vld), .out_data(out_data)
  );

  function automatic longint ref_out(longint x0, longint x1, longint x2);
    return longint'(coef_a) * x0 + longint'(coef_b) * x1 + longint'(coef_c) * x2;
  endfunction

  task automatic chk(string tag, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic clear_model();
    h1 = 0; h2 = 0;
    for (int i = 0; i < 8; i++) begin slot_v[i] = 1'b0; slot_d[i] = 0; end
  endtask

  // called at a negedge; leaves at the following negedge
  task automatic tick(string tag, bit v, longint d);
    int k;
    in_vld  = v;
    in_data = DW'(d);
    @(posedge clk);
    cyc++;
    k = cyc;
    if (v) begin
      slot_v[(k + 3) % 8] = 1'b1;
      slot_d[(k + 3) % 8] = ref_out(longint'(in_data), h1, h2);
      h2 = h1;
      h1 = longint'(in_data);
    end
    @(negedge clk);
    chk(tag, longint'(out_vld), longint'(slot_v[k % 8]), "out_vld");
    if (slot_v[k % 8]) chk(tag, longint'(out_data), slot_d[k % 8], "out_data");
    slot_v[k % 8] = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    // R4: outputs cleared by reset
    chk("R4", longint'(out_vld), 0, "out_vld after reset");
    chk("R4", longint'(out_data), 0, "out_data after reset");
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 5; i++) tick(tag, 1'b0, longint'($signed(DW'($urandom))));
  endtask

  task automatic set_coefs(longint a, longint b, longint c);
    coef_a = CW'(a); coef_b = CW'(b); coef_c = CW'(c);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clear_model();
    @(negedge clk);
    set_coefs(3, -5, 7);
    do_reset();

    // R4 / R2: first sample over zero history, exact arrival cycle
    tick("R4", 1'b1, 100);
    tick("R2", 1'b0, 0);
    tick("R2", 1'b0, 0);
    tick("R2", 1'b0, 0);
    tick("R4", 1'b1, -20);
    drain("R2");

    // R1: back-to-back stream
    for (int i = 0; i < 40; i++) tick("R1", 1'b1, longint'($signed(DW'($urandom))));
    drain("R1");

    // R3, R6: random bubbles carrying random data
    for (int r = 0; r < 6; r++) begin
      set_coefs(longint'($signed(CW'($urandom))), longint'($signed(CW'($urandom))),
                longint'($signed(CW'($urandom))));
      for (int i = 0; i < 60; i++) begin
        bit v = ($urandom % 10) < 6;
        tick(v ? "R3" : "R6", v, longint'($signed(DW'($urandom))));
      end
      drain("R3");
    end

    // R6: directed bubble with extreme garbage between two samples
    set_coefs(1, 2, 4);
    tick("R6", 1'b1, 10);
    tick("R6", 1'b0, -2048);
    tick("R6", 1'b0, 2047);
    tick("R6", 1'b1, 20);
    tick("R6", 1'b1, 30);
    drain("R6");

    // R5: extremes and all-ones low coefficient parts
    set_coefs(-512, -512, -512);
    for (int i = 0; i < 4; i++) tick("R5", 1'b1, -2048);
    drain("R5");
    set_coefs(511, -1, 31);
    for (int i = 0; i < 4; i++) tick("R5", 1'b1, 2047);
    for (int i = 0; i < 4; i++) tick("R5", 1'b1, -2048);
    drain("R5");
    set_coefs(-481, 0, -512);
    for (int i = 0; i < 4; i++) tick("R5", 1'b1, i[0] ? 2047 : -2048);
    drain("R5");

    // R7: reset with samples in flight
    set_coefs(9, 8, 7);
    tick("R7", 1'b1, 11);
    tick("R7", 1'b1, 22);
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 5; i++) tick("R7", 1'b0, 0);
    tick("R7", 1'b1, 5);
    drain("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule